// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Qualifier

The block compares two pulse streams, a reference and a feedback stream, both sampled in the oscillator clock domain. It decides which one arrived first and reports that as up and down requests. It also produces a three-state control for an external charge pump: a drive enable and a drive level. The time between the first and the second arriving edge is counted in oscillator clocks. That count feeds a lock qualifier, which declares lock only after several consecutive small-error comparisons and drops lock on one large error.

A polarity input swaps the sense of the up/down outputs and of the pump level, so the loop can be matched to a voltage-controlled oscillator with either gain slope. A monitor output shows either the lock flag or one of the two input streams; which stream it shows depends on the polarity. An active-low pump enable forces the pump into the floating state. An active-low power input puts the block into a power-save state. In that state the phase state and the lock history are held cleared, the pump floats and the lock output reads high.

Top module: `pfd_lock_top`

## Requirements
- R1: After reset, up_o, dn_o and pump_oe are low and lock_o is low (with pwr_on high).
- R2: The rising edge of an input is the first cycle in which it is sampled high after being low. When the reference edge arrives d ≥ 1 cycles before the feedback edge, the internal up request is high alone for d cycles, starting in the cycle after the reference edge. During those cycles pump_oe is high.
- R3: When the feedback edge arrives first, the internal down request is high alone for d cycles, and pump_oe is high during them.
- R4: On the edge that ends a comparison, both up_o and dn_o are high for exactly one cycle and pump_oe is low. This also holds when both edges arrive in the same cycle (d = 0). In the next cycle both are low.
- R5: With pol = 1, up_o carries the up request and pump_lvl = 1 means drive high (reference leads). With pol = 0, up_o and dn_o are swapped and pump_lvl is inverted, so a leading reference gives dn_o = 1 and pump_lvl = 0.
- R6: Further edges of the leading input, before the lagging edge arrives, do not end the comparison: the lead request stays high until the other edge arrives (frequency-detecting behaviour).
- R7: A comparison with error d ≤ LOCK_WIN (default 2) counts as good. lock_o rises in the cycle after the LOCK_CNT-th (default 3) consecutive good comparison ends.
- R8: A comparison with d ≥ UNLOCK_TH (default 4) clears lock_o in the next cycle. A comparison with LOCK_WIN < d < UNLOCK_TH leaves lock_o unchanged but restarts the good-comparison count.
- R9: While pump_en is low, pump_oe is low whatever the phase state; up_o and dn_o are unaffected.
- R10: While pwr_on is low, up_o, dn_o and pump_oe are low and lock_o is high. After pwr_on returns high, lock_o is low and no stale up or down request remains.
- R11: With mon_sel = 1, mon_o follows ref_i when pol = 1 and fb_i when pol = 0. With mon_sel = 0, mon_o equals lock_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference pulse stream |
| fb_i | input | 1 | Feedback pulse stream |
| pol | input | 1 | Polarity select |
| mon_sel | input | 1 | Monitor select: 1 = input stream, 0 = lock flag |
| pump_en | input | 1 | Active-low pump float control (low forces float) |
| pwr_on | input | 1 | Low selects power-save |
| up_o | output | 1 | Up request (after polarity) |
| dn_o | output | 1 | Down request (after polarity) |
| pump_oe | output | 1 | Pump drive enable; low means float |
| pump_lvl | output | 1 | Pump drive level when enabled |
| lock_o | output | 1 | Lock flag |
| mon_o | output | 1 | Monitor output |

## Verification
The bench runs many comparisons with random leader, error and polarity. It checks each lead cycle, the closing overlap cycle and the return to idle. A design that left off the overlap pulse would show a dead zone at zero error, and a swapped polarity path would drive the pump the wrong way. Directed runs walk the lock qualifier through a third good comparison, a mid-window error that must restart the count without dropping lock, and a large error that must drop it. A qualifier that counted non-consecutive comparisons, or that dropped lock on the hysteresis band, fails here. Other directed runs check that repeated leading edges keep the lead request up, that power-save leaves no stale request behind, and the pump float and monitor selections.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_REF_LEAD = 2'd1,
      ST_FB_LEAD  = 2'd2,
      ST_OVERLAP  = 2'd3
   } pfd_state_e;
endpackage

// File: rtl/pfd_phase_core.sv
module pfd_phase_core
   import pfd_lock_pkg::*;
#(
   parameter int ERR_SAT     = 4,
   parameter int SYNC_STAGES = 0,
   localparam int ERR_W      = $clog2(ERR_SAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ref_i,
   input  logic             fb_i,
   output logic             up_o,
   output logic             dn_o,
   output logic             done_o,
   output logic [ERR_W-1:0] err_o
);
   logic ref_s, fb_s, ref_q, fb_q, ref_ev, fb_ev;
   pfd_state_e st_q, st_d;
   logic [ERR_W-1:0] cnt_q, cnt_d;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign ref_s = ref_i;
         assign fb_s  = fb_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] rs_q, fs_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rs_q <= '0;
               fs_q <= '0;
            end else begin
               rs_q <= {rs_q[SYNC_STAGES-1:0], ref_i} >> 0;
               fs_q <= {fs_q[SYNC_STAGES-1:0], fb_i} >> 0;
            end
         end
         assign ref_s = rs_q[SYNC_STAGES-1];
         assign fb_s  = fs_q[SYNC_STAGES-1];
      end
      if (ERR_SAT < 1) begin : g_bad_sat
         $error("ERR_SAT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= 1'b0;
         fb_q  <= 1'b0;
      end else begin
         ref_q <= ref_s;
         fb_q  <= fb_s;
      end
   end

   assign ref_ev = ref_s & ~ref_q;
   assign fb_ev  = fb_s & ~fb_q;

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      done_o = 1'b0;
      unique case (st_q)
         ST_REF_LEAD: begin
            if (fb_ev) begin
               st_d   = ST_OVERLAP;
               done_o = 1'b1;
            end else if (cnt_q < ERR_W'(ERR_SAT)) begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_FB_LEAD: begin
            if (ref_ev) begin
               st_d   = ST_OVERLAP;
               done_o = 1'b1;
            end else if (cnt_q < ERR_W'(ERR_SAT)) begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            cnt_d = ERR_W'(1);
            if (ref_ev && fb_ev) begin
               st_d   = ST_OVERLAP;
               done_o = 1'b1;
               cnt_d  = '0;
            end else if (ref_ev) begin
               st_d = ST_REF_LEAD;
            end else if (fb_ev) begin
               st_d = ST_FB_LEAD;
            end else begin
               st_d  = ST_IDLE;
               cnt_d = '0;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else if (clr) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign up_o  = (st_q == ST_REF_LEAD) || (st_q == ST_OVERLAP);
   assign dn_o  = (st_q == ST_FB_LEAD)  || (st_q == ST_OVERLAP);
   assign err_o = (st_q == ST_IDLE || st_q == ST_OVERLAP) ? '0 : cnt_q;

   // R4: every finished comparison is followed by the overlap cycle
   p_done_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n || clr)
      done_o |=> (up_o && dn_o));
   // R6: a lead request only ends through the overlap cycle
   p_lead_ends_in_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (up_o && !dn_o) |=> (up_o));
endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual #(
   parameter int ERR_W     = 3,
   parameter int LOCK_WIN  = 2,
   parameter int UNLOCK_TH = 4,
   parameter int LOCK_CNT  = 3,
   localparam int GOOD_W   = $clog2(LOCK_CNT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             done_i,
   input  logic [ERR_W-1:0] err_i,
   output logic             locked_o
);
   logic [GOOD_W-1:0] good_q;
   logic              is_good, is_bad;

   generate
      if (LOCK_WIN >= UNLOCK_TH) begin : g_bad_win
         $error("LOCK_WIN must be below UNLOCK_TH");
      end
      if (LOCK_CNT < 1) begin : g_bad_cnt
         $error("LOCK_CNT must be at least 1");
      end
   endgenerate

   assign is_good = (int'(err_i) <= LOCK_WIN);
   assign is_bad  = (int'(err_i) >= UNLOCK_TH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_q   <= '0;
         locked_o <= 1'b0;
      end else if (clr) begin
         good_q   <= '0;
         locked_o <= 1'b0;
      end else if (done_i) begin
         if (is_good) begin
            if (int'(good_q) + 1 >= LOCK_CNT) begin
               locked_o <= 1'b1;
               good_q   <= GOOD_W'(LOCK_CNT);
            end else begin
               good_q <= good_q + 1'b1;
            end
         end else begin
            good_q <= '0;
            if (is_bad) locked_o <= 1'b0;
         end
      end
   end

   // R8: a large error never leaves lock asserted
   p_unlock_on_large_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (done_i && is_bad) |=> !locked_o);
   // R7: lock only rises on a finished comparison
   p_lock_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n || clr)
      $rose(locked_o) |-> $past(done_i));
endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage (
   input  logic pol,
   input  logic mon_sel,
   input  logic pump_en,
   input  logic active,
   input  logic up_i,
   input  logic dn_i,
   input  logic locked_i,
   input  logic ref_i,
   input  logic fb_i,
   output logic up_o,
   output logic dn_o,
   output logic pump_oe,
   output logic pump_lvl,
   output logic lock_o,
   output logic mon_o
);
   logic up_g, dn_g;
   assign up_g     = up_i & active;
   assign dn_g     = dn_i & active;
   assign up_o     = pol ? up_g : dn_g;
   assign dn_o     = pol ? dn_g : up_g;
   assign pump_oe  = pump_en & (up_g ^ dn_g);
   assign pump_lvl = up_o;
   assign lock_o   = locked_i | ~active;
   assign mon_o    = mon_sel ? (pol ? ref_i : fb_i) : lock_o;
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
   parameter int LOCK_WIN    = 2,
   parameter int UNLOCK_TH   = 4,
   parameter int LOCK_CNT    = 3,
   parameter int SYNC_STAGES = 0,
   localparam int ERR_W      = $clog2(UNLOCK_TH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_i,
   input  logic fb_i,
   input  logic pol,
   input  logic mon_sel,
   input  logic pump_en,
   input  logic pwr_on,
   output logic up_o,
   output logic dn_o,
   output logic pump_oe,
   output logic pump_lvl,
   output logic lock_o,
   output logic mon_o
);
   logic             up_int, dn_int, done, locked;
   logic [ERR_W-1:0] err;

   pfd_phase_core #(.ERR_SAT(UNLOCK_TH), .SYNC_STAGES(SYNC_STAGES)) u_core (
      .clk(clk), .rst_n(rst_n), .clr(~pwr_on), .ref_i(ref_i), .fb_i(fb_i),
      .up_o(up_int), .dn_o(dn_int), .done_o(done), .err_o(err));

   pfd_lock_qual #(.ERR_W(ERR_W), .LOCK_WIN(LOCK_WIN), .UNLOCK_TH(UNLOCK_TH),
                   .LOCK_CNT(LOCK_CNT)) u_lock (
      .clk(clk), .rst_n(rst_n), .clr(~pwr_on), .done_i(done), .err_i(err),
      .locked_o(locked));

   pfd_out_stage u_out (
      .pol(pol), .mon_sel(mon_sel), .pump_en(pump_en), .active(pwr_on),
      .up_i(up_int), .dn_i(dn_int), .locked_i(locked), .ref_i(ref_i), .fb_i(fb_i),
      .up_o(up_o), .dn_o(dn_o), .pump_oe(pump_oe), .pump_lvl(pump_lvl),
      .lock_o(lock_o), .mon_o(mon_o));

   // R10: power-save silences the pump and requests and reads as locked
   p_psave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |-> (lock_o && !pump_oe && !up_o && !dn_o));
   // R9: float control overrides the phase state
   p_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pump_en |-> !pump_oe);
   // R4: the pump never drives while both requests are high
   p_overlap_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_o && dn_o) |-> !pump_oe);
endmodule

// File: tb/pfd_lock_top_tb.sv
module pfd_lock_top_tb_top;
   logic clk = 1'b0, rst_n = 1'b0;
   logic ref_i = 0, fb_i = 0, pol = 1, mon_sel = 0, pump_en = 1, pwr_on = 1;
   logic up_o, dn_o, pump_oe, pump_lvl, lock_o, mon_o;
   int checks = 0, errors = 0;
   int m_good = 0;
   bit m_lock = 0;

   always #5 clk = ~clk;

   pfd_lock_top dut_i (.clk(clk), .rst_n(rst_n), .ref_i(ref_i), .fb_i(fb_i), .pol(pol),
      .mon_sel(mon_sel), .pump_en(pump_en), .pwr_on(pwr_on), .up_o(up_o), .dn_o(dn_o),
      .pump_oe(pump_oe), .pump_lvl(pump_lvl), .lock_o(lock_o), .mon_o(mon_o));

   task automatic chk(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // lock model: rules of R7 and R8
   function automatic void model_lock(input int d);
      if (d <= 2) begin
         m_good = (m_good + 1 > 3) ? 3 : m_good + 1;
         if (m_good >= 3) m_lock = 1;
      end else begin
         m_good = 0;
         if (d >= 4) m_lock = 0;
      end
   endfunction

   // one comparison: leader first, the other edge d cycles later
   task automatic compare(input bit ref_first, input int d);
      bit up_exp;
      int derr;
      up_exp = (ref_first == pol);
      derr = d > 4 ? 4 : d;
      @(negedge clk);
      if (d == 0) begin ref_i = 1; fb_i = 1; end
      else if (ref_first) ref_i = 1; else fb_i = 1;
      @(posedge clk);
      @(negedge clk);
      ref_i = 0; fb_i = 0;
      for (int j = 1; j <= d; j++) begin
         chk(up_o, up_exp, "R2/R3/R5 lead up");
         chk(dn_o, !up_exp, "R2/R3/R5 lead dn");
         chk(pump_oe, 1, "R2/R3 pump drives");
         chk(pump_lvl, up_exp, "R5 pump level");
         if (j == d) begin
            if (ref_first) fb_i = 1; else ref_i = 1;
         end
         @(posedge clk);
         @(negedge clk);
         ref_i = 0; fb_i = 0;
      end
      chk(up_o & dn_o, 1, "R4 overlap both");
      chk(pump_oe, 0, "R4 overlap float");
      model_lock(derr);
      chk(lock_o, m_lock, "R7/R8 lock state");
      @(posedge clk);
      @(negedge clk);
      chk(up_o | dn_o, 0, "R4 idle after overlap");
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int seed;
      seed = 17;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      chk(up_o | dn_o, 0, "R1 reset requests");
      chk(pump_oe, 0, "R1 reset pump");
      chk(lock_o, 0, "R1 reset lock");

      // R7: three good comparisons give lock
      pol = 1;
      compare(1, 1);
      compare(0, 2);
      chk(lock_o, 0, "R7 not yet locked");
      compare(1, 0);
      chk(lock_o, 1, "R7 locked after third");
      // R8: hysteresis band keeps lock, restarts count
      compare(1, 3);
      chk(lock_o, 1, "R8 band holds lock");
      compare(0, 5);
      chk(lock_o, 0, "R8 large error unlocks");

      // R5 with pol low
      pol = 0;
      compare(1, 2);
      compare(0, 3);

      // R6: second leading edge keeps up request
      pol = 1;
      @(negedge clk); ref_i = 1;
      @(negedge clk); ref_i = 0;
      @(negedge clk); ref_i = 1;
      @(negedge clk); ref_i = 0;
      chk(up_o, 1, "R6 lead held");
      chk(dn_o, 0, "R6 no overlap");
      // R9: float while leading
      pump_en = 0;
      #1 chk(pump_oe, 0, "R9 forced float");
      chk(up_o, 1, "R9 requests unaffected");
      pump_en = 1;
      // R10: power-save mid comparison
      pwr_on = 0;
      #1 chk(lock_o, 1, "R10 lock high in save");
      chk(up_o | dn_o | pump_oe, 0, "R10 quiet in save");
      // R11 monitor while saving
      mon_sel = 0;
      #1 chk(mon_o, 1, "R11 monitor shows lock");
      mon_sel = 1; ref_i = 1; fb_i = 0; pol = 1;
      #1 chk(mon_o, 1, "R11 monitor ref");
      pol = 0;
      #1 chk(mon_o, 0, "R11 monitor fb");
      ref_i = 0; fb_i = 1;
      #1 chk(mon_o, 1, "R11 monitor fb high");
      fb_i = 0; pol = 1; mon_sel = 0;
      @(negedge clk); @(negedge clk);
      pwr_on = 1;
      @(negedge clk);
      chk(lock_o, 0, "R10 lock cleared on exit");
      chk(up_o | dn_o, 0, "R10 no stale request");
      m_good = 0; m_lock = 0;

      // random mix
      for (int i = 0; i < 300; i++) begin
         pol = 1'($urandom_range(0, 1));
         compare(1'($urandom_range(0, 1)), $urandom_range(0, 6));
         repeat ($urandom_range(0, 2)) @(negedge clk);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule